// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a byte-wide SPI master that software drives through a bank of 32-bit word registers. Bytes written to the transmit data register queue in a 16-entry transmit FIFO. A shift engine pops each byte and sends it on MOSI while it clocks a byte in from MISO. The received byte goes into a 16-entry receive FIFO, where software reads it from the receive data register. The control register sets the clock polarity and phase, the bit order and the internal loopback. It also holds the run-permission bits and the hold bit that freezes the engine.

Up to 32 active-low select lines come from a select register. In manual mode the register drives the lines directly. In automatic mode the chosen line is low only while a byte is on the wire. Interrupt flags latch FIFO events and software clears them by writing ones. A keyed write to the reset register returns the whole block to its power-on state. The SCK half-period is a fixed number of system clocks, set by a parameter.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the registers read as follows: control (word 0x60) 0x180, status (0x64) 0x25, select (0x70) 0xFFFFFFFF, interrupt flags (0x20) 0, and both occupancy registers (0x74 TX, 0x78 RX) 0. The irq output is low, all select lines are high and SCK is low.
- R2: A byte leaves the transmit FIFO only when control bit 1 (enable) and bit 2 (master) are both set and bit 8 (hold) is clear. Otherwise queued bytes stay queued and no select line is driven.
- R3: SCK rests at the level of control bit 3 (polarity). With control bit 4 (phase) clear, data is sampled on the edge leaving the rest level. With it set, data is sampled on the edge returning to the rest level. Each byte takes 8 SCK cycles.
- R4: With control bit 9 clear, each byte is sent and received most significant bit first. With bit 9 set, it is sent and received least significant bit first.
- R5: With control bit 0 set, the receive path takes MOSI internally, so each byte read from the receive data register (0x6C) equals the byte sent. With bit 0 clear, the byte is captured from the MISO pin.
- R6: With control bit 7 set, the select lines follow the select register at all times. With bit 7 clear, they follow the register only while a byte is in flight and are otherwise all high. Clearing register bit n drives line n low.
- R7: Each FIFO holds 16 bytes. Each occupancy register reports the byte count minus one in bits 3:0, and 0 when empty. Status bit 0 is RX empty, bit 1 RX full, bit 2 TX empty, bit 3 TX full, bit 4 mode fault (always 0) and bit 5 slave-select idle (always 1).
- R8: A write to transmit data (0x68) while the TX FIFO is full drops the byte and sets interrupt flag bit 3. A read of receive data while the RX FIFO is empty returns 0.
- R9: Writing control bit 5 empties the TX FIFO and writing bit 6 empties the RX FIFO, both in one cycle. Both bits always read back as 0.
- R10: Each interrupt flag latches high on its event and is cleared by writing 1 to it at 0x20. The irq output is high when bit 31 of 0x1C is set and any flag is set together with its enable bit at 0x28.
- R11: Writing exactly 0x0000000A to 0x40 restores every register and both FIFOs to the reset state. Any other value written there changes nothing.
- R12: The interrupt flags are set by these events. Bit 8 is set when a byte enters the RX FIFO. Bit 4 is set when the RX FIFO becomes full. Bit 5 is set when a received byte is dropped because the RX FIFO is full. Bit 2 is set when a byte finishes and the TX FIFO is empty. Bit 7 is set when a pop leaves 8 bytes in the TX FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 7 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave select lines |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 32 select lines, 16-byte FIFOs and an SCK half-period of 2 clocks. The short half-period keeps a byte to 33 clocks. That makes it cheap to fill the receive FIFO to 16 bytes and then push two more bytes to reach the overrun case. The 17th transmit write exercises the full-drop path. The full 32-bit select width lets the walking-zero select patterns reach the highest line. A bus monitor samples MOSI on the edge each polarity and phase setting calls for. With MISO tied to inverted MOSI, loopback and pin capture give results that can be told apart.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Register word index (byte address bits 6:2).
    typedef enum logic [4:0] {
        W_GIE   = 5'h07,
        W_ISR   = 5'h08,
        W_IER   = 5'h0A,
        W_SRST  = 5'h10,
        W_CTRL  = 5'h18,
        W_STAT  = 5'h19,
        W_TXD   = 5'h1A,
        W_RXD   = 5'h1B,
        W_SSEL  = 5'h1C,
        W_TXOCC = 5'h1D,
        W_RXOCC = 5'h1E
    } reg_word_e;

    typedef struct packed {
        logic lsb_first;   // bit 9
        logic hold;        // bit 8
        logic manual_ss;   // bit 7
        logic rx_flush;    // bit 6
        logic tx_flush;    // bit 5
        logic cpha;        // bit 4
        logic cpol;        // bit 3
        logic master;      // bit 2
        logic enable;      // bit 1
        logic loopback;    // bit 0
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(10'h180);
    localparam logic [31:0] SRST_KEY = 32'h0000_000A;

    localparam int unsigned IRQ_W       = 9;
    localparam int unsigned IB_TX_EMPTY = 2;
    localparam int unsigned IB_TX_OVF   = 3;
    localparam int unsigned IB_RX_FULL  = 4;
    localparam int unsigned IB_RX_OVR   = 5;
    localparam int unsigned IB_TX_HALF  = 7;
    localparam int unsigned IB_RX_NE    = 8;

    function automatic logic out_bit(logic [7:0] cur, logic lsb);
        return lsb ? cur[0] : cur[7];
    endfunction

    function automatic logic [7:0] shift_out(logic [7:0] cur, logic lsb);
        return lsb ? {1'b0, cur[7:1]} : {cur[6:0], 1'b0};
    endfunction

    function automatic logic [7:0] shift_in(logic [7:0] cur, logic b, logic lsb);
        return lsb ? {b, cur[7:1]} : {cur[6:0], b};
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r8_full_drops: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == $past(count)));

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int unsigned SCK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       tx_avail,
    input  logic [7:0] tx_byte,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       lsb_first,
    input  logic       loopback,
    input  logic       miso,
    output logic       tx_pop,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       rx_push,
    output logic [7:0] rx_byte
);
    localparam int unsigned DW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;

    logic       busy_q, lvl_q, tick;
    logic [3:0] edge_q;
    logic [7:0] tx_sh, rx_sh, rx_next;
    logic       miso_in, sample_now, shift_now, last_edge;

    generate
        if (SCK_DIV == 1) begin : g_nodiv
            assign tick = busy_q;
        end else begin : g_div
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || tx_pop || !busy_q || tick) div_q <= '0;
                else                                  div_q <= div_q + 1'b1;
            end
            assign tick = busy_q && (div_q == DW'(SCK_DIV - 1));
        end
    endgenerate

    assign tx_pop     = !busy_q && go && tx_avail;
    assign mosi       = out_bit(tx_sh, lsb_first);
    assign miso_in    = loopback ? mosi : miso;
    assign rx_next    = shift_in(rx_sh, miso_in, lsb_first);
    // even edges leave the rest level, odd edges return to it
    assign sample_now = tick && (cpha ? edge_q[0] : !edge_q[0]);
    assign shift_now  = tick && (cpha ? (!edge_q[0] && edge_q != 4'd0) : edge_q[0]);
    assign last_edge  = tick && (edge_q == 4'd15);
    assign rx_push    = last_edge;
    assign rx_byte    = sample_now ? rx_next : rx_sh;
    assign sck        = cpol ^ lvl_q;
    assign busy       = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            lvl_q  <= 1'b0;
            edge_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else if (tx_pop) begin
            busy_q <= 1'b1;
            lvl_q  <= 1'b0;
            edge_q <= '0;
            tx_sh  <= tx_byte;
            rx_sh  <= '0;
        end else if (tick) begin
            lvl_q  <= ~lvl_q;
            edge_q <= edge_q + 1'b1;
            if (sample_now) rx_sh <= rx_next;
            if (shift_now)  tx_sh <= shift_out(tx_sh, lsb_first);
            if (last_edge)  busy_q <= 1'b0;
        end
    end

    a_r3_sck_rest: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (sck == cpol));

    a_r2_pop_starts: assert property (@(posedge clk) disable iff (rst)
        tx_pop |=> busy_q);

    a_r5_one_push: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !rx_push);

endmodule

// File: rtl/spim_irq.sv
module spim_irq #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] en_mask,
    input  logic         gie,
    output logic [W-1:0] flags,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~(clr_we ? clr_mask : '0)) | ev;
    end

    assign irq = gie && |(flags & en_mask);

    a_r10_event_latches: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> gie);

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int unsigned NUM_SS     = 32,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned SCK_DIV    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              irq
);
    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);
    localparam int unsigned PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

    reg_word_e   word;
    logic        aligned, wr_hit, rd_hit;
    logic        srst, rst_all;
    ctrl_t       ctrl_q, ctrl_wval;
    logic [NUM_SS-1:0] ss_q;
    logic [IRQ_W-1:0]  ier_q, isr, ev;
    logic        gie_q;

    assign word    = reg_word_e'(reg_addr[6:2]);
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign wr_hit  = reg_wr && aligned;
    assign rd_hit  = reg_rd && aligned;
    assign srst    = wr_hit && (word == W_SRST) && (reg_wdata == SRST_KEY);
    assign rst_all = rst || srst;

    logic wr_ctrl, tx_flush, rx_flush, tx_push, rx_pop, go;
    assign wr_ctrl  = wr_hit && (word == W_CTRL);
    assign tx_flush = wr_ctrl && reg_wdata[5];
    assign rx_flush = wr_ctrl && reg_wdata[6];
    assign tx_push  = wr_hit && (word == W_TXD);
    assign rx_pop   = rd_hit && (word == W_RXD);
    assign go       = ctrl_q.enable && ctrl_q.master && !ctrl_q.hold;

    always_comb begin
        ctrl_wval          = ctrl_t'(reg_wdata[9:0]);
        ctrl_wval.tx_flush = 1'b0;
        ctrl_wval.rx_flush = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst_all) begin
            ctrl_q <= CTRL_RST;
            ss_q   <= '1;
            ier_q  <= '0;
            gie_q  <= 1'b0;
        end else if (wr_hit) begin
            case (word)
                W_CTRL:  ctrl_q <= ctrl_wval;
                W_SSEL:  ss_q   <= reg_wdata[NUM_SS-1:0];
                W_IER:   ier_q  <= reg_wdata[IRQ_W-1:0];
                W_GIE:   gie_q  <= reg_wdata[31];
                default: ;
            endcase
        end
    end

    // FIFOs
    logic [7:0]    tx_dout, rx_dout, sh_rx_byte;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_empty, tx_full, rx_empty, rx_full;
    logic          sh_tx_pop, sh_rx_push, sh_busy;

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst_all), .flush(tx_flush), .push(tx_push), .pop(sh_tx_pop),
        .din(reg_wdata[7:0]), .dout(tx_dout), .count(tx_count),
        .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst_all), .flush(rx_flush), .push(sh_rx_push), .pop(rx_pop),
        .din(sh_rx_byte), .dout(rx_dout), .count(rx_count),
        .empty(rx_empty), .full(rx_full)
    );

    spim_shift #(.SCK_DIV(SCK_DIV)) u_eng (
        .clk(clk), .rst(rst_all), .go(go), .tx_avail(!tx_empty), .tx_byte(tx_dout),
        .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .lsb_first(ctrl_q.lsb_first),
        .loopback(ctrl_q.loopback), .miso(miso), .tx_pop(sh_tx_pop), .sck(sck),
        .mosi(mosi), .busy(sh_busy), .rx_push(sh_rx_push), .rx_byte(sh_rx_byte)
    );

    // interrupt events
    always_comb begin
        ev              = '0;
        ev[IB_TX_OVF]   = tx_push && tx_full;
        ev[IB_RX_OVR]   = sh_rx_push && rx_full;
        ev[IB_RX_NE]    = sh_rx_push && !rx_full;
        ev[IB_RX_FULL]  = sh_rx_push && !rx_full && !rx_pop
                          && (rx_count == CW'(FIFO_DEPTH - 1));
        ev[IB_TX_EMPTY] = sh_rx_push && tx_empty;
        ev[IB_TX_HALF]  = sh_tx_pop && !(tx_push && !tx_full)
                          && (tx_count == CW'(FIFO_DEPTH / 2 + 1));
    end

    spim_irq #(.W(IRQ_W)) u_irq (
        .clk(clk), .rst(rst_all), .ev(ev),
        .clr_we(wr_hit && (word == W_ISR)), .clr_mask(reg_wdata[IRQ_W-1:0]),
        .en_mask(ier_q), .gie(gie_q), .flags(isr), .irq(irq)
    );

    assign ss_n = (ctrl_q.manual_ss || sh_busy) ? ss_q : '1;

    // register read mux
    logic [PW-1:0] tx_occ, rx_occ;
    assign tx_occ = tx_empty ? '0 : PW'(tx_count - 1'b1);
    assign rx_occ = rx_empty ? '0 : PW'(rx_count - 1'b1);

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            case (word)
                W_GIE:   reg_rdata[31] = gie_q;
                W_ISR:   reg_rdata[IRQ_W-1:0] = isr;
                W_IER:   reg_rdata[IRQ_W-1:0] = ier_q;
                W_CTRL:  reg_rdata[9:0] = ctrl_q;
                W_STAT:  reg_rdata[5:0] = {1'b1, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
                W_RXD:   reg_rdata[7:0] = rx_empty ? 8'h00 : rx_dout;
                W_SSEL:  reg_rdata[NUM_SS-1:0] = ss_q;
                W_TXOCC: reg_rdata[PW-1:0] = tx_occ;
                W_RXOCC: reg_rdata[PW-1:0] = rx_occ;
                default: ;
            endcase
        end
    end

    a_r2_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        !go |-> !sh_tx_pop);

    a_r6_auto_release: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.manual_ss && !sh_busy) |-> (ss_n == '1));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (tx_flush && !srst) |=> (tx_count == '0));

    a_r11_key_resets: assert property (@(posedge clk) disable iff (rst)
        srst |=> (ctrl_q == CTRL_RST && isr == '0 && !gie_q));

endmodule

// File: tb/sim_spim_ctrl.sv
module sim_spim_ctrl;
    localparam int NSS = 32, DEPTH = 16, DIV = 2;
    localparam int BYTE_CYC = 16 * DIV + 1;
    localparam logic [6:0] AD_GIE = 7'h1C, AD_ISR = 7'h20, AD_IER = 7'h28,
        AD_SRST = 7'h40, AD_CTRL = 7'h60, AD_STAT = 7'h64, AD_TXD = 7'h68,
        AD_RXD = 7'h6C, AD_SSEL = 7'h70, AD_TXOCC = 7'h74, AD_RXOCC = 7'h78;

    logic clk = 1'b0, rst = 1'b1;
    always #5 clk = ~clk;

    logic reg_wr = 0, reg_rd = 0, sck, mosi, miso, irq;
    logic [6:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [NSS-1:0] ss_n;
    assign miso = ~mosi;

    spim_ctrl #(.NUM_SS(NSS), .FIFO_DEPTH(DEPTH), .SCK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .ss_n(ss_n), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] rev8(logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [31:0] ctrl_word(bit lsb, bit hold, bit man, bit cpha,
                                              bit cpol, bit mst, bit en, bit loop);
        return {22'b0, lsb, hold, man, 2'b00, cpha, cpol, mst, en, loop};
    endfunction

    // bus monitor: sample MOSI on the edge the mode calls for
    bit m_on = 0, m_cpol = 0, m_cpha = 0;
    logic [7:0] m_sh;
    int m_bits = 0, m_cnt = 0, ss_bad = 0;
    logic [7:0] m_got [32];
    logic [NSS-1:0] m_ss_exp;

    always @(sck) begin
        if (m_on && (((sck != m_cpol) ? 1'b1 : 1'b0) ^ m_cpha)) begin
            if (m_bits == 0 && ss_n !== m_ss_exp) ss_bad++;
            m_sh = {m_sh[6:0], mosi};
            m_bits++;
            if (m_bits == 8) begin
                if (m_cnt < 32) m_got[m_cnt] = m_sh;
                m_cnt++;
                m_bits = 0;
            end
        end
    end

    task automatic run_xfer(bit cpol, bit cpha, bit lsb, bit loop, int nb, int sel);
        logic [7:0] tx [16];
        logic [31:0] d;
        string tag;
        tag = $sformatf("R3/R4/R5 mode cpol=%0d cpha=%0d lsb=%0d loop=%0d", cpol, cpha, lsb, loop);
        m_on = 0;
        wr(AD_SSEL, ~(32'd1 << sel));
        wr(AD_CTRL, ctrl_word(lsb, 0, 0, cpha, cpol, 1, 1, loop));
        m_cpol = cpol; m_cpha = cpha; m_ss_exp = ~(32'd1 << sel);
        m_cnt = 0; m_bits = 0; ss_bad = 0;
        idle(2);
        check({tag, " R3 sck rest"}, {31'b0, sck}, {31'b0, cpol});
        m_on = 1;
        for (int i = 0; i < nb; i++) begin
            tx[i] = 8'($urandom);
            wr(AD_TXD, {24'b0, tx[i]});
        end
        idle(nb * (BYTE_CYC + 2) + 20);
        m_on = 0;
        check({tag, " byte count on wire"}, m_cnt, nb);
        for (int i = 0; i < nb; i++)
            check({tag, " R4 wire byte"}, {24'b0, m_got[i]}, {24'b0, lsb ? rev8(tx[i]) : tx[i]});
        check({tag, " R6 select during byte"}, ss_bad, 0);
        check({tag, " R6 auto release"}, ss_n, '1);
        check({tag, " R3 sck back at rest"}, {31'b0, sck}, {31'b0, cpol});
        for (int i = 0; i < nb; i++) begin
            rd(AD_RXD, d);
            check({tag, " R5 rx byte"}, d, {24'b0, loop ? tx[i] : ~tx[i]});
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [7:0] rb [18];
        void'($urandom(32'h0005_EED1));
        idle(3);
        rst = 0;
        idle(2);

        // R1 reset state
        rd(AD_CTRL, d);  check("R1 control reset", d, 32'h180);
        rd(AD_STAT, d);  check("R1 status reset", d, 32'h25);
        rd(AD_SSEL, d);  check("R1 select reset", d, 32'hFFFF_FFFF);
        rd(AD_ISR, d);   check("R1 flags reset", d, 0);
        rd(AD_TXOCC, d); check("R1 tx occupancy reset", d, 0);
        rd(AD_RXOCC, d); check("R1 rx occupancy reset", d, 0);
        check("R1 irq low", {31'b0, irq}, 0);
        check("R1 sck low", {31'b0, sck}, 0);
        check("R1 select lines high", ss_n, '1);

        // R2 gating
        wr(AD_SSEL, 32'hFFFF_FFFE);
        wr(AD_CTRL, ctrl_word(0, 1, 0, 0, 0, 1, 1, 1));
        wr(AD_TXD, 32'h5A);
        idle(80);
        rd(AD_STAT, d);  check("R2 hold keeps byte queued", d, 32'h21);
        check("R2 no select while held", ss_n, '1);
        wr(AD_CTRL, ctrl_word(0, 0, 0, 0, 0, 0, 1, 1));
        idle(80);
        rd(AD_STAT, d);  check("R2 master clear keeps byte queued", d, 32'h21);
        wr(AD_CTRL, ctrl_word(0, 0, 0, 0, 0, 1, 1, 1));
        idle(BYTE_CYC + 10);
        rd(AD_RXD, d);   check("R2 byte sent once permitted", d, 32'h5A);
        rd(AD_STAT, d);  check("R2 status idle after", d, 32'h25);

        // R3 R4 R5 R6: all modes, both orders, loopback then pin capture
        for (int m = 0; m < 8; m++)
            run_xfer(m[0], m[1], m[2], 1, 3, (m * 5) % NSS);
        run_xfer(0, 0, 0, 0, 3, 31);
        run_xfer(1, 1, 1, 0, 3, 17);

        // R6 manual select
        wr(AD_CTRL, ctrl_word(0, 1, 1, 0, 0, 0, 0, 0));
        wr(AD_SSEL, 32'hFFFF_FFF7);
        idle(1);
        check("R6 manual select follows register", ss_n, 32'hFFFF_FFF7);
        wr(AD_CTRL, ctrl_word(0, 0, 0, 0, 0, 1, 1, 1));
        idle(1);
        check("R6 auto select idle high", ss_n, '1);
        wr(AD_CTRL, ctrl_word(0, 0, 1, 0, 0, 1, 1, 1));
        wr(AD_TXD, 32'hC3);
        idle(BYTE_CYC + 10);
        check("R6 manual select kept after byte", ss_n, 32'hFFFF_FFF7);
        rd(AD_RXD, d);   check("R5 manual mode byte", d, 32'hC3);

        // R7 R8 R9 transmit fill, overflow, flush
        wr(AD_ISR, 32'h1FF);
        wr(AD_CTRL, ctrl_word(0, 1, 1, 0, 0, 1, 1, 0));
        for (int i = 0; i < DEPTH; i++) wr(AD_TXD, 32'($urandom) & 32'hFF);
        rd(AD_TXOCC, d); check("R7 tx occupancy full", d, 32'hF);
        rd(AD_STAT, d);  check("R7 status tx full", d, 32'h29);
        rd(AD_ISR, d);   check("R8 no overflow yet", d & 32'h8, 0);
        wr(AD_TXD, 32'hEE);
        rd(AD_ISR, d);   check("R8 overflow flag", d & 32'h8, 32'h8);
        rd(AD_TXOCC, d); check("R8 dropped byte", d, 32'hF);
        wr(AD_CTRL, ctrl_word(0, 1, 1, 0, 0, 1, 1, 0) | 32'h20);
        rd(AD_TXOCC, d); check("R9 tx flush", d, 0);
        rd(AD_STAT, d);  check("R9 status empty after flush", d, 32'h25);
        rd(AD_CTRL, d);  check("R9 flush bit self-clears", d, 32'h186);

        // R12 receive fill and overrun
        wr(AD_ISR, 32'h1FF);
        wr(AD_CTRL, ctrl_word(0, 0, 0, 0, 0, 1, 1, 1));
        for (int i = 0; i < DEPTH; i++) begin
            rb[i] = 8'($urandom);
            wr(AD_TXD, {24'b0, rb[i]});
        end
        idle(DEPTH * BYTE_CYC + 40);
        rd(AD_RXOCC, d); check("R7 rx occupancy full", d, 32'hF);
        rd(AD_STAT, d);  check("R7 status rx full tx empty", d, 32'h26);
        rd(AD_ISR, d);   check("R12 flags after fill", d, 32'h194);
        wr(AD_TXD, 32'h11);
        wr(AD_TXD, 32'h22);
        idle(2 * BYTE_CYC + 20);
        rd(AD_ISR, d);   check("R12 overrun flag", d & 32'h20, 32'h20);
        rd(AD_RXOCC, d); check("R12 overrun drops byte", d, 32'hF);
        for (int i = 0; i < DEPTH; i++) begin
            rd(AD_RXD, d);
            check("R12 rx order kept", d, {24'b0, rb[i]});
        end
        rd(AD_RXD, d);   check("R8 empty read returns 0", d, 0);

        // R9 rx flush
        wr(AD_TXD, 32'h77);
        idle(BYTE_CYC + 10);
        wr(AD_CTRL, ctrl_word(0, 0, 0, 0, 0, 1, 1, 1) | 32'h40);
        rd(AD_STAT, d);  check("R9 rx flush", d & 32'h1, 32'h1);

        // R10 interrupt gating
        wr(AD_IER, 32'h100);
        idle(1);
        check("R10 irq needs global enable", {31'b0, irq}, 0);
        wr(AD_GIE, 32'h8000_0000);
        idle(1);
        check("R10 irq raised", {31'b0, irq}, 1);
        wr(AD_ISR, 32'h100);
        idle(1);
        check("R10 irq cleared by write-one", {31'b0, irq}, 0);
        rd(AD_ISR, d);   check("R10 only written flag cleared", d & 32'h104, 32'h004);
        rd(AD_IER, d);   check("R10 enable readback", d, 32'h100);
        rd(AD_GIE, d);   check("R10 global readback", d, 32'h8000_0000);

        // R11 soft reset
        wr(AD_SRST, 32'h5);
        rd(AD_CTRL, d);  check("R11 wrong key ignored", d, 32'h7);
        rd(AD_GIE, d);   check("R11 wrong key keeps global", d, 32'h8000_0000);
        wr(AD_SRST, 32'hA);
        rd(AD_CTRL, d);  check("R11 control restored", d, 32'h180);
        rd(AD_GIE, d);   check("R11 global restored", d, 0);
        rd(AD_IER, d);   check("R11 enables restored", d, 0);
        rd(AD_ISR, d);   check("R11 flags restored", d, 0);
        rd(AD_SSEL, d);  check("R11 select restored", d, 32'hFFFF_FFFF);
        rd(AD_STAT, d);  check("R11 status restored", d, 32'h25);
        check("R11 irq low", {31'b0, irq}, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule